// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This block is the combinational interlock logic for a five-stage in-order integer pipeline with the stages fetch, decode, execute, memory and writeback. Each cycle it looks at the source register numbers of the instruction in decode and the instruction in execute. It compares them with the destination register numbers and write enables of the older instructions that are still in flight.

From that comparison it picks a bypass source for each ALU operand of the instruction in execute. It also raises a hold on the program counter and the fetch/decode register, a bubble for the decode/execute register, and a discard for wrong-path instructions while a branch or jump in execute is still unresolved.

The elaboration parameter `FULL_FWD` picks the variant. With it set, results are bypassed and only a load followed at once by a consumer costs a cycle. With it clear, there is no bypassing, and a consumer waits until every producer it depends on has reached writeback. The register file is expected to write in the first half of a cycle and read in the second half.

Top module: `hazardUnit`

## Requirements
- R1: In full-forwarding mode, an operand of the execute-stage instruction whose register matches the memory-stage destination (write enable set, register not 0) gets select code 2'b10.
- R2: In full-forwarding mode, an operand that matches only the writeback-stage destination (write enable set, register not 0) gets select code 2'b01. With no match the code is 2'b00 (register file).
- R3: When both the memory-stage and writeback-stage destinations match an operand, the younger memory-stage result wins (code 2'b10). Code 2'b11 never appears.
- R4: Register 0 never causes a bypass, hold or bubble, and a producer whose write enable is clear never matches.
- R5: A load in execute whose destination is a source of the decode-stage instruction raises stallFront and bubbleEx for that cycle, in both modes.
- R6: In full-forwarding mode, a non-load producer in execute or any producer in memory or writeback causes no hold.
- R7: In no-forwarding mode both select outputs stay 2'b00 whatever the matches.
- R8: In no-forwarding mode, stallFront and bubbleEx are raised while a matching producer sits in execute or memory. A matching producer in writeback alone causes no hold.
- R9: While ctlUnresolved is high, flushFront and bubbleEx are high and stallFront is low, even when a hold would otherwise apply.
- R10: stallFront is never high without bubbleEx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idRs1 | input | AW | First source register of the decode-stage instruction |
| idRs2 | input | AW | Second source register of the decode-stage instruction |
| exRs1 | input | AW | First source register of the execute-stage instruction (ALU input A) |
| exRs2 | input | AW | Second source register of the execute-stage instruction (ALU input B) |
| exRd | input | AW | Destination register of the execute-stage instruction |
| exRegWrite | input | 1 | Execute-stage instruction writes a register |
| exMemRead | input | 1 | Execute-stage instruction is a load |
| memRd | input | AW | Destination register held in the execute/memory register |
| memRegWrite | input | 1 | Memory-stage instruction writes a register |
| wbRd | input | AW | Destination register held in the memory/writeback register |
| wbRegWrite | input | 1 | Writeback-stage instruction writes a register |
| ctlUnresolved | input | 1 | A branch or jump in execute has not resolved its target yet |
| fwdSelA | output | 2 | Bypass select for ALU input A |
| fwdSelB | output | 2 | Bypass select for ALU input B |
| stallFront | output | 1 | Hold the PC and the fetch/decode register |
| bubbleEx | output | 1 | Load a no-op into the decode/execute register |
| flushFront | output | 1 | Discard the instruction in the fetch/decode register |

## Verification
The bench builds two copies of the block from the same stimulus, one with `FULL_FWD` = 1 and one with `FULL_FWD` = 0, and uses the default register width of 5. With both copies side by side, one input pattern shows both behaviours. A plain ALU producer directly ahead of its consumer bypasses in one copy and holds in the other. A load-use pair holds in both, and a producer in writeback is free in both. The same comparison checks that the no-forwarding copy never drives a bypass select, and that a pending branch overrides the hold in either mode.

// File: rtl/hazPkg.sv
package hazPkg;

  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } fwdSel_e;

  typedef struct packed {
    logic stallFront;
    logic bubbleEx;
    logic flushFront;
  } ctlStrobe_t;

endpackage

// File: rtl/srcMatch.sv
module srcMatch #(
  parameter int AW      = 5,
  parameter int NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0][AW-1:0] srcRegs,
  input  logic [AW-1:0]              prodRd,
  input  logic                       prodWrite,
  output logic [NUM_SRC-1:0]         hit
);
  logic prodLive;
  assign prodLive = prodWrite && (prodRd != '0);

  for (genvar s = 0; s < NUM_SRC; s++) begin : gSrc
    assign hit[s] = prodLive && (srcRegs[s] == prodRd);
  end
endmodule

// File: rtl/fwdPath.sv
module fwdPath
  import hazPkg::*;
#(
  parameter int AW       = 5,
  parameter int NUM_SRC  = 2,
  parameter bit FULL_FWD = 1'b1
) (
  input  logic [NUM_SRC-1:0][AW-1:0] exRs,
  input  logic [AW-1:0]              memRd,
  input  logic                       memRegWrite,
  input  logic [AW-1:0]              wbRd,
  input  logic                       wbRegWrite,
  output fwdSel_e [NUM_SRC-1:0]      fwdSel
);
  logic [NUM_SRC-1:0] memHit;
  logic [NUM_SRC-1:0] wbHit;

  srcMatch #(.AW(AW), .NUM_SRC(NUM_SRC)) uMemCmp (
    .srcRegs(exRs), .prodRd(memRd), .prodWrite(memRegWrite), .hit(memHit)
  );
  srcMatch #(.AW(AW), .NUM_SRC(NUM_SRC)) uWbCmp (
    .srcRegs(exRs), .prodRd(wbRd), .prodWrite(wbRegWrite), .hit(wbHit)
  );

  for (genvar s = 0; s < NUM_SRC; s++) begin : gOp
    fwdSel_e pick;
    // younger stage first
    always_comb begin
      if (memHit[s])     pick = SEL_MEM;
      else if (wbHit[s]) pick = SEL_WB;
      else               pick = SEL_RF;
    end
    assign fwdSel[s] = FULL_FWD ? pick : SEL_RF;

    always_comb begin
      if (exRs[s] == '0) begin
        assert_zero_no_fwd_R4: assert (fwdSel[s] == SEL_RF)
          else $error("register 0 bypassed");
      end
      assert_sel_code_R3: assert (fwdSel[s] != fwdSel_e'(2'b11))
        else $error("illegal bypass code");
    end
  end
endmodule

// File: rtl/hazCtl.sv
module hazCtl
  import hazPkg::*;
#(
  parameter int AW       = 5,
  parameter int NUM_SRC  = 2,
  parameter bit FULL_FWD = 1'b1
) (
  input  logic [NUM_SRC-1:0][AW-1:0] idRs,
  input  logic [AW-1:0]              exRd,
  input  logic                       exRegWrite,
  input  logic                       exMemRead,
  input  logic [AW-1:0]              memRd,
  input  logic                       memRegWrite,
  input  logic                       ctlUnresolved,
  output ctlStrobe_t                 strobe
);
  logic [NUM_SRC-1:0] exHit;
  logic [NUM_SRC-1:0] memHit;
  logic loadUse;
  logic anyInFlight;
  logic holdNeed;

  srcMatch #(.AW(AW), .NUM_SRC(NUM_SRC)) uExCmp (
    .srcRegs(idRs), .prodRd(exRd), .prodWrite(exRegWrite), .hit(exHit)
  );
  srcMatch #(.AW(AW), .NUM_SRC(NUM_SRC)) uMemCmp (
    .srcRegs(idRs), .prodRd(memRd), .prodWrite(memRegWrite), .hit(memHit)
  );

  assign loadUse     = exMemRead && (|exHit);
  assign anyInFlight = (|exHit) || (|memHit);
  assign holdNeed    = FULL_FWD ? loadUse : anyInFlight;

  // a pending redirect kills the decode instruction, so no hold is needed
  assign strobe.flushFront = ctlUnresolved;
  assign strobe.stallFront = holdNeed && !ctlUnresolved;
  assign strobe.bubbleEx   = holdNeed || ctlUnresolved;

  always_comb begin
    if (strobe.stallFront) begin
      assert_stall_bubble_R10: assert (strobe.bubbleEx)
        else $error("hold without bubble");
    end
    if (ctlUnresolved) begin
      assert_flush_wins_R9: assert (!strobe.stallFront && strobe.bubbleEx && strobe.flushFront)
        else $error("redirect strobes wrong");
    end
    if (exMemRead && exRegWrite && exRd != '0 && !ctlUnresolved &&
        (idRs[0] == exRd || idRs[NUM_SRC-1] == exRd)) begin
      assert_load_use_R5: assert (strobe.stallFront)
        else $error("load-use not held");
    end
  end
endmodule

// File: rtl/hazardUnit.sv
module hazardUnit
  import hazPkg::*;
#(
  parameter int AW       = 5,
  parameter bit FULL_FWD = 1'b1
) (
  input  logic [AW-1:0] idRs1,
  input  logic [AW-1:0] idRs2,
  input  logic [AW-1:0] exRs1,
  input  logic [AW-1:0] exRs2,
  input  logic [AW-1:0] exRd,
  input  logic          exRegWrite,
  input  logic          exMemRead,
  input  logic [AW-1:0] memRd,
  input  logic          memRegWrite,
  input  logic [AW-1:0] wbRd,
  input  logic          wbRegWrite,
  input  logic          ctlUnresolved,
  output logic [1:0]    fwdSelA,
  output logic [1:0]    fwdSelB,
  output logic          stallFront,
  output logic          bubbleEx,
  output logic          flushFront
);
  localparam int NUM_SRC = 2;

  logic [NUM_SRC-1:0][AW-1:0] idRsVec;
  logic [NUM_SRC-1:0][AW-1:0] exRsVec;
  fwdSel_e [NUM_SRC-1:0]      selVec;
  ctlStrobe_t                 strobe;

  assign idRsVec = {idRs2, idRs1};
  assign exRsVec = {exRs2, exRs1};

  fwdPath #(.AW(AW), .NUM_SRC(NUM_SRC), .FULL_FWD(FULL_FWD)) uPath (
    .exRs(exRsVec), .memRd(memRd), .memRegWrite(memRegWrite),
    .wbRd(wbRd), .wbRegWrite(wbRegWrite), .fwdSel(selVec)
  );

  hazCtl #(.AW(AW), .NUM_SRC(NUM_SRC), .FULL_FWD(FULL_FWD)) uCtl (
    .idRs(idRsVec), .exRd(exRd), .exRegWrite(exRegWrite), .exMemRead(exMemRead),
    .memRd(memRd), .memRegWrite(memRegWrite), .ctlUnresolved(ctlUnresolved),
    .strobe(strobe)
  );

  assign fwdSelA    = selVec[0];
  assign fwdSelB    = selVec[1];
  assign stallFront = strobe.stallFront;
  assign bubbleEx   = strobe.bubbleEx;
  assign flushFront = strobe.flushFront;

  always_comb begin
    if (!FULL_FWD) begin
      assert_nofwd_sel_R7: assert (fwdSelA == 2'b00 && fwdSelB == 2'b00)
        else $error("bypass in no-forwarding mode");
    end
  end
endmodule

// File: tb/tb_hazardUnit.sv
`timescale 1ns/1ps
module tb_hazardUnit;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic [AW-1:0] idRs1, idRs2, exRs1, exRs2, exRd, memRd, wbRd;
  logic exRegWrite, exMemRead, memRegWrite, wbRegWrite, ctlUnresolved;

  logic [1:0] fSelA, fSelB, nSelA, nSelB;
  logic fStall, fBub, fFlush, nStall, nBub, nFlush;

  hazardUnit #(.AW(AW), .FULL_FWD(1'b1)) dut (
    .idRs1(idRs1), .idRs2(idRs2), .exRs1(exRs1), .exRs2(exRs2),
    .exRd(exRd), .exRegWrite(exRegWrite), .exMemRead(exMemRead),
    .memRd(memRd), .memRegWrite(memRegWrite), .wbRd(wbRd), .wbRegWrite(wbRegWrite),
    .ctlUnresolved(ctlUnresolved), .fwdSelA(fSelA), .fwdSelB(fSelB),
    .stallFront(fStall), .bubbleEx(fBub), .flushFront(fFlush)
  );

  hazardUnit #(.AW(AW), .FULL_FWD(1'b0)) dutNoFwd (
    .idRs1(idRs1), .idRs2(idRs2), .exRs1(exRs1), .exRs2(exRs2),
    .exRd(exRd), .exRegWrite(exRegWrite), .exMemRead(exMemRead),
    .memRd(memRd), .memRegWrite(memRegWrite), .wbRd(wbRd), .wbRegWrite(wbRegWrite),
    .ctlUnresolved(ctlUnresolved), .fwdSelA(nSelA), .fwdSelB(nSelB),
    .stallFront(nStall), .bubbleEx(nBub), .flushFront(nFlush)
  );

  typedef struct {
    string      tag;
    logic [1:0] selA;
    logic [1:0] selB;
    logic [2:0] fCtl;   // stall, bubble, flush (full mode)
    logic [2:0] nCtl;   // stall, bubble, flush (no-forwarding mode)
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic startVec();
    @(posedge clk);
    idRs1 = '0; idRs2 = '0; exRs1 = '0; exRs2 = '0;
    exRd = '0; memRd = '0; wbRd = '0;
    exRegWrite = 1'b0; exMemRead = 1'b0; memRegWrite = 1'b0;
    wbRegWrite = 1'b0; ctlUnresolved = 1'b0;
  endtask

  task automatic pushExp(string tag, logic [1:0] a, logic [1:0] b,
                         logic [2:0] fc, logic [2:0] nc);
    expItem_t it;
    it.tag = tag; it.selA = a; it.selB = b; it.fCtl = fc; it.nCtl = nc;
    expQ.push_back(it);
  endtask

  // monitor: compares away from the active edge
  always @(negedge clk) begin
    if (rstN && expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      checks++;
      if (fSelA !== it.selA || fSelB !== it.selB || {fStall, fBub, fFlush} !== it.fCtl) begin
        errors++;
        $display("FAIL %s full: sel=%b/%b ctl=%b expected sel=%b/%b ctl=%b",
                 it.tag, fSelA, fSelB, {fStall, fBub, fFlush}, it.selA, it.selB, it.fCtl);
      end
      checks++;
      if (nSelA !== 2'b00 || nSelB !== 2'b00 || {nStall, nBub, nFlush} !== it.nCtl) begin
        errors++;
        $display("FAIL %s nofwd: sel=%b/%b ctl=%b expected sel=00/00 ctl=%b",
                 it.tag, nSelA, nSelB, {nStall, nBub, nFlush}, it.nCtl);
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    startVec();
    repeat (2) @(posedge clk);
    rstN = 1'b1;

    // idle / reset state: nothing in flight
    startVec();
    pushExp("R4 idle", 2'b00, 2'b00, 3'b000, 3'b000);

    // R1 / R7: memory-stage producer feeds operand A
    startVec(); exRs1 = 5'd3; idRs1 = 5'd7; memRd = 5'd3; memRegWrite = 1'b1;
    pushExp("R1/R7 mem bypass A", 2'b10, 2'b00, 3'b000, 3'b000);

    // R2 / R8: writeback-stage producer feeds operand B, no hold anywhere
    startVec(); exRs2 = 5'd4; idRs2 = 5'd4; wbRd = 5'd4; wbRegWrite = 1'b1;
    pushExp("R2/R8 wb bypass B", 2'b00, 2'b01, 3'b000, 3'b000);

    // R3: both stages match, younger wins
    startVec(); exRs1 = 5'd5; exRs2 = 5'd5; memRd = 5'd5; wbRd = 5'd5;
    memRegWrite = 1'b1; wbRegWrite = 1'b1;
    pushExp("R3 priority", 2'b10, 2'b10, 3'b000, 3'b000);

    // R3: mem matches A, wb matches B
    startVec(); exRs1 = 5'd8; exRs2 = 5'd9; memRd = 5'd8; wbRd = 5'd9;
    memRegWrite = 1'b1; wbRegWrite = 1'b1;
    pushExp("R3 split", 2'b10, 2'b01, 3'b000, 3'b000);

    // R4: register 0 everywhere, loads included
    startVec(); memRd = 5'd0; memRegWrite = 1'b1; wbRegWrite = 1'b1;
    exRd = 5'd0; exRegWrite = 1'b1; exMemRead = 1'b1;
    pushExp("R4 reg zero", 2'b00, 2'b00, 3'b000, 3'b000);

    // R4: write enable clear means no match
    startVec(); exRs1 = 5'd6; idRs1 = 5'd6; memRd = 5'd6; exRd = 5'd6;
    exMemRead = 1'b1; wbRd = 5'd6;
    pushExp("R4 no write", 2'b00, 2'b00, 3'b000, 3'b000);

    // R5: load-use on second decode source
    startVec(); idRs2 = 5'd9; exRd = 5'd9; exRegWrite = 1'b1; exMemRead = 1'b1;
    pushExp("R5 load-use", 2'b00, 2'b00, 3'b110, 3'b110);

    // R6 / R8: plain ALU producer in execute
    startVec(); idRs1 = 5'd9; exRd = 5'd9; exRegWrite = 1'b1;
    pushExp("R6/R8 alu in ex", 2'b00, 2'b00, 3'b000, 3'b110);

    // R6 / R8: producer in memory stage
    startVec(); idRs1 = 5'd11; memRd = 5'd11; memRegWrite = 1'b1;
    pushExp("R6/R8 producer in mem", 2'b00, 2'b00, 3'b000, 3'b110);

    // R8: producer in writeback only
    startVec(); idRs1 = 5'd12; wbRd = 5'd12; wbRegWrite = 1'b1;
    pushExp("R8 wb only", 2'b00, 2'b00, 3'b000, 3'b000);

    // R9: redirect overrides a load-use hold
    startVec(); idRs1 = 5'd9; exRd = 5'd9; exRegWrite = 1'b1; exMemRead = 1'b1;
    ctlUnresolved = 1'b1;
    pushExp("R9 flush over hold", 2'b00, 2'b00, 3'b011, 3'b011);

    // R9: redirect alone
    startVec(); ctlUnresolved = 1'b1;
    pushExp("R9 flush", 2'b00, 2'b00, 3'b011, 3'b011);

    // R10 / R5: load-use on both sources with a bypass in execute
    startVec(); idRs1 = 5'd13; idRs2 = 5'd13; exRd = 5'd13; exRegWrite = 1'b1;
    exMemRead = 1'b1; exRs1 = 5'd2; memRd = 5'd2; memRegWrite = 1'b1;
    pushExp("R10/R5 hold with bubble", 2'b10, 2'b00, 3'b110, 3'b110);

    repeat (3) @(posedge clk);
    finishRun();
  end
endmodule